// File: doc/BRIEF.md
# Time-of-Day Counter with Indexed Register Access

This block keeps wall-clock time for a real-time clock. It holds seconds, minutes, hours, day, month, year and century. Each field advances once for every pulse on a one-second tick input. A carry passes from seconds up through century within the same clock cycle as the tick.

Software reaches the block through a two-location byte port. A write to the index location selects a register. Reads and writes at the data location then act on the selected register. Two control registers set the behaviour:

- Fields are stored either as packed BCD or as plain binary.
- Hours run either 0 to 23, or 1 to 12 with a PM flag.
- Counting stops while the divider code is anything other than the run code, or while a freeze bit is set. Software loads new values during that time.

Top module: `tod_counter`

## Requirements
- R1: After reset the registers hold these values:

  | Register | Reset value |
  |---|---|
  | seconds | 0x00 |
  | minutes | 0x00 |
  | hours | 0x00 |
  | day | 0x01 |
  | month | 0x01 |
  | year | 0x00 |
  | century | 0x20 |
  | control A | 0x26 |
  | control B | 0x02 |

  Index map: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 century, 7 control A, 8 control B.
- R2: `bus_rdata_o` always shows the register selected by the latched index. Indexes 9 and above read 0x00 and ignore writes.
- R3: When control B bit 2 is 1, every field is counted in plain binary. For example, 9:59:59 in 24-hour mode becomes 0x0A:0x00:0x00.
- R4: Seconds and minutes wrap from 59 to 0 and carry into the next field on the same tick. In BCD, 0x09:0x59:0x59 becomes 0x10:0x00:0x00.
- R5: When control B bit 1 is 0, hours run 1 to 12 and bit 7 marks PM. The transitions are:
  - 11 AM goes to 12 PM (bit 7 set).
  - 12 PM goes to 1 PM.
  - 11 PM goes to 12 AM (bit 7 clear), carrying into the day.
  - 12 AM goes to 1 AM.
- R6: In 24-hour mode, hour 23 wraps to 0 and carries into the day. The day wraps from `DAY_LAST` to 1 and carries into the month. The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0 and carries into the century. The century wraps from 99 to 0.
- R7: Fields advance only while control A bits 6:4 equal 3'b010. Writing 0x76 to control A stops counting, and writing 0x26 restarts it.
- R8: While control B bit 7 is 1, no field advances and written values read back unchanged. Clearing the bit resumes counting.
- R9: A data-port write in the same cycle as a tick stores the written value, and that tick is dropped for every field.
- R10: A write to the index location latches the low `IDX_W` bits of the written byte as the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| bus_we_i | input | 1 | Write strobe for the byte port |
| bus_addr_i | input | 1 | 0 selects the index location, 1 selects the data location |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Contents of the selected register |

## Verification
The bench builds the block with `DAY_LAST` set to 28 and `IDX_W` left at 4. The short month lets the day-to-month carry, and the month-to-year and year-to-century carries behind it, be reached with a single tick after a direct load. The 4-bit index reaches past the last register, so the unmapped read-as-zero path is exercised.

The bench loads each rollover corner while the clock is frozen and then releases it, so every boundary is reached in one tick. It runs the 12-hour sequence in both encodings. It also places a data write exactly on a tick pulse.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned NF        = 7;
  localparam int unsigned F_HOUR    = 2;
  localparam int unsigned IDX_CTLA  = 7;
  localparam int unsigned IDX_CTLB  = 8;
  localparam int unsigned B_SET     = 7;
  localparam int unsigned B_BIN     = 2;
  localparam int unsigned B_H24     = 1;
  localparam logic [2:0]  DIV_RUN   = 3'b010;
  localparam logic [7:0]  CTLA_RST  = 8'h26;
  localparam logic [7:0]  CTLB_RST  = 8'h02;

  function automatic logic [6:0] dec_val(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return 7'(int'(v[7:4]) * 10 + int'(v[3:0]));
  endfunction

  function automatic logic [7:0] enc_val(input logic [6:0] n, input logic bin);
    if (bin) return {1'b0, n};
    return {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  function automatic int unsigned field_lo(input int unsigned g);
    return (g == 3 || g == 4) ? 1 : 0;
  endfunction

  function automatic int unsigned field_hi(input int unsigned g, input int unsigned day_last);
    case (g)
      0, 1:    return 59;
      3:       return day_last;
      4:       return 12;
      default: return 99;
    endcase
  endfunction

  function automatic logic [7:0] field_rst(input int unsigned g);
    case (g)
      3, 4:    return 8'h01;
      6:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tod_host_port.sv
module tod_host_port #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [7:0]       wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             data_we_o
);
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  assign idx_en    = we_i & ~addr_i;
  assign data_we_o = we_i & addr_i;

  always_comb begin
    idx_d = idx_o;
    if (idx_en) idx_d = wdata_i[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_o <= '0;
    else        idx_o <= idx_d;
  end
endmodule

// File: rtl/tod_field.sv
module tod_field import tod_pkg::*; #(
  parameter int unsigned LO = 0,
  parameter int unsigned HI = 59
) (
  input  logic [7:0] cur_i,
  input  logic       bin_i,
  input  logic       inc_i,
  output logic [7:0] nxt_o,
  output logic       carry_o
);
  logic [6:0] v;

  always_comb begin
    v       = dec_val(cur_i, bin_i);
    carry_o = inc_i && (v >= 7'(HI));
    nxt_o   = cur_i;
    if (inc_i) nxt_o = carry_o ? enc_val(7'(LO), bin_i) : enc_val(v + 7'd1, bin_i);
  end
endmodule

// File: rtl/tod_hour_step.sv
module tod_hour_step import tod_pkg::*; (
  input  logic [7:0] cur_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic       inc_i,
  output logic [7:0] nxt_o,
  output logic       carry_o
);
  logic [6:0] v24;
  logic [6:0] h12;
  logic       pm;
  logic [7:0] e12;
  logic [7:0] e1;
  logic [7:0] eup;

  always_comb begin
    v24     = dec_val(cur_i, bin_i);
    h12     = dec_val({1'b0, cur_i[6:0]}, bin_i);
    pm      = cur_i[7];
    e12     = enc_val(7'd12, bin_i);
    e1      = enc_val(7'd1, bin_i);
    eup     = enc_val(h12 + 7'd1, bin_i);
    nxt_o   = cur_i;
    carry_o = 1'b0;
    if (inc_i) begin
      if (h24_i) begin
        carry_o = (v24 >= 7'd23);
        nxt_o   = carry_o ? enc_val(7'd0, bin_i) : enc_val(v24 + 7'd1, bin_i);
      end else if (h12 == 7'd11) begin
        carry_o = pm;
        nxt_o   = {~pm, e12[6:0]};
      end else if (h12 >= 7'd12 || h12 == 7'd0) begin
        nxt_o   = {pm, e1[6:0]};
      end else begin
        nxt_o   = {pm, eup[6:0]};
      end
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter import tod_pkg::*; #(
  parameter int unsigned DAY_LAST = 31,
  parameter int unsigned IDX_W    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       bus_we_i,
  input  logic       bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o
);
  localparam int unsigned SEL_W = $clog2(NF);

  logic [1:0]       rst_pipe;
  logic             rst_s;
  logic [IDX_W-1:0] idx_q;
  logic             data_we;
  logic [7:0]       time_q  [NF];
  logic [7:0]       time_d  [NF];
  logic [7:0]       time_nx [NF];
  logic [7:0]       ctla_q, ctla_d, ctlb_q, ctlb_d;
  logic [NF:0]      inc;
  logic             run;
  logic             cen_wrap;

  // reset asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  tod_host_port #(.IDX_W(IDX_W)) u_port (
    .clk(clk), .rst_n(rst_s), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .idx_o(idx_q), .data_we_o(data_we)
  );

  assign run      = (ctla_q[6:4] == DIV_RUN) && !ctlb_q[B_SET];
  assign inc[0]   = tick_i & run & ~data_we;
  assign cen_wrap = inc[NF];

  for (genvar g = 0; g < NF; g++) begin : g_fld
    if (g == F_HOUR) begin : g_hr
      tod_hour_step u_hr (
        .cur_i(time_q[g]), .bin_i(ctlb_q[B_BIN]), .h24_i(ctlb_q[B_H24]),
        .inc_i(inc[g]), .nxt_o(time_nx[g]), .carry_o(inc[g+1])
      );
    end else begin : g_gen
      tod_field #(.LO(field_lo(g)), .HI(field_hi(g, DAY_LAST))) u_f (
        .cur_i(time_q[g]), .bin_i(ctlb_q[B_BIN]), .inc_i(inc[g]),
        .nxt_o(time_nx[g]), .carry_o(inc[g+1])
      );
    end
  end

  always_comb begin
    for (int g = 0; g < NF; g++) time_d[g] = time_nx[g];
    ctla_d = ctla_q;
    ctlb_d = ctlb_q;
    if (data_we) begin
      if (idx_q < IDX_W'(NF))              time_d[idx_q[SEL_W-1:0]] = bus_wdata_i;
      else if (idx_q == IDX_W'(IDX_CTLA))  ctla_d = bus_wdata_i;
      else if (idx_q == IDX_W'(IDX_CTLB))  ctlb_d = bus_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int g = 0; g < NF; g++) time_q[g] <= field_rst(g);
      ctla_q <= CTLA_RST;
      ctlb_q <= CTLB_RST;
    end else begin
      for (int g = 0; g < NF; g++) time_q[g] <= time_d[g];
      ctla_q <= ctla_d;
      ctlb_q <= ctlb_d;
    end
  end

  always_comb begin
    bus_rdata_o = 8'h00;
    if (idx_q < IDX_W'(NF))             bus_rdata_o = time_q[idx_q[SEL_W-1:0]];
    else if (idx_q == IDX_W'(IDX_CTLA)) bus_rdata_o = ctla_q;
    else if (idx_q == IDX_W'(IDX_CTLB)) bus_rdata_o = ctlb_q;
  end
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             we,
  input logic             addr,
  input logic [7:0]       wdata,
  input logic [IDX_W-1:0] idx,
  input logic [7:0]       sec,
  input logic [7:0]       min,
  input logic [7:0]       cen,
  input logic [7:0]       ctla,
  input logic [7:0]       ctlb,
  input logic             cen_wrap
);
  logic dw;
  assign dw = we & addr;

  AST_IDX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr) |=> idx == $past(wdata[IDX_W-1:0])); // R10
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && idx == '0) |=> sec == $past(wdata)); // R9
  AST_TICK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && idx != '0) |=> $stable(sec)); // R9
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dw && ctla[6:4] != 3'b010) |=> $stable(sec)); // R7
  AST_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dw && ctlb[7]) |=> $stable(sec)); // R8
  AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !dw && ctla[6:4] == 3'b010 && !ctlb[7]) |=> !$stable(sec)); // R4
  AST_MIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    !dw |=> ($stable(min) || sec == 8'h00)); // R4
  AST_CEN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_wrap && !dw) |=> cen == 8'h00); // R6
endmodule

bind tod_counter tod_counter_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .tick(tick_i), .we(bus_we_i), .addr(bus_addr_i),
  .wdata(bus_wdata_i), .idx(idx_q), .sec(time_q[0]), .min(time_q[1]),
  .cen(time_q[6]), .ctla(ctla_q), .ctlb(ctlb_q), .cen_wrap(cen_wrap)
);

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tod_counter #(.DAY_LAST(28), .IDX_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic wr(input logic [7:0] i, input logic [7:0] v);
    @(negedge clk); we = 1'b1; addr = 1'b0; wdata = i;
    @(negedge clk); addr = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0; addr = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // driver: select register, then queue the expected value for the monitor
  task automatic expect_reg(input logic [7:0] i, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk); we = 1'b1; addr = 1'b0; wdata = i;
    @(negedge clk); we = 1'b0;
    it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic load(input logic [7:0] b, input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(7, 8'h76); wr(8, b); wr(2, h); wr(1, m); wr(0, s); wr(7, 8'h26);
  endtask

  task automatic hour_step(input logic [7:0] b, input logic [7:0] h, input logic [7:0] e, input string tag);
    load(b, h, 8'h59, 8'h59);
    ticks(1);
    expect_reg(2, e, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    expect_reg(0, 8'h00, "R1 sec");
    expect_reg(2, 8'h00, "R1 hour");
    expect_reg(3, 8'h01, "R1 day");
    expect_reg(6, 8'h20, "R1 century");
    expect_reg(7, 8'h26, "R1 ctlA");
    expect_reg(8, 8'h02, "R1 ctlB");
    // R2 / R10 indexed access
    wr(5, 8'h80); wr(6, 8'h20);
    expect_reg(5, 8'h80, "R2 R10 year");
    expect_reg(6, 8'h20, "R2 century");
    wr(15, 8'h5A);
    expect_reg(15, 8'h00, "R2 unmapped");
    // R7 divider hold
    wr(7, 8'h76); wr(2, 8'h09); wr(1, 8'h59); wr(0, 8'h58);
    ticks(3);
    expect_reg(0, 8'h58, "R7 frozen sec");
    wr(7, 8'h26);
    ticks(1);
    expect_reg(0, 8'h59, "R7 resumed sec");
    ticks(1);
    expect_reg(0, 8'h00, "R4 sec wrap");
    expect_reg(1, 8'h00, "R4 min wrap");
    expect_reg(2, 8'h10, "R4 bcd hour");
    // R6 day step, then full chain
    wr(3, 8'h05);
    load(8'h02, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_reg(2, 8'h00, "R6 hour wrap");
    expect_reg(3, 8'h06, "R6 day step");
    wr(3, 8'h28); wr(4, 8'h12); wr(5, 8'h99); wr(6, 8'h20);
    load(8'h02, 8'h23, 8'h59, 8'h59);
    ticks(1);
    expect_reg(3, 8'h01, "R6 day wrap");
    expect_reg(4, 8'h01, "R6 month wrap");
    expect_reg(5, 8'h00, "R6 year wrap");
    expect_reg(6, 8'h21, "R6 century carry");
    // R5 12-hour BCD
    hour_step(8'h00, 8'h11, 8'h92, "R5 11AM->12PM");
    hour_step(8'h00, 8'h92, 8'h81, "R5 12PM->1PM");
    hour_step(8'h00, 8'h91, 8'h12, "R5 11PM->12AM");
    hour_step(8'h00, 8'h12, 8'h01, "R5 12AM->1AM");
    // R3 binary
    hour_step(8'h06, 8'h09, 8'h0A, "R3 bin 24h hour");
    expect_reg(1, 8'h00, "R3 bin min");
    hour_step(8'h04, 8'h8B, 8'h0C, "R3 R5 bin 11PM");
    hour_step(8'h04, 8'h0B, 8'h8C, "R3 R5 bin 11AM");
    hour_step(8'h04, 8'h8C, 8'h81, "R3 R5 bin 12PM");
    // R8 SET freeze
    wr(8, 8'h82); wr(1, 8'h04); wr(0, 8'h58);
    ticks(2);
    expect_reg(0, 8'h58, "R8 set sec");
    expect_reg(1, 8'h04, "R8 set min");
    wr(8, 8'h02);
    ticks(1);
    expect_reg(0, 8'h59, "R8 resumed");
    // R9 write on a tick
    wr(0, 8'h10);
    @(negedge clk); we = 1'b1; addr = 1'b0; wdata = 8'd1;
    @(negedge clk); addr = 1'b1; wdata = 8'h30; tick = 1'b1;
    @(negedge clk); we = 1'b0; addr = 1'b0; tick = 1'b0;
    expect_reg(1, 8'h30, "R9 written min");
    expect_reg(0, 8'h10, "R9 tick dropped");
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule